// File: doc/BRIEF.md
# Stepped Volume and Soft-Mute Gain Stage

This block scales a stereo stream of 24-bit signed audio samples. A sample pair is presented with a one-cycle strobe, and the scaled pair comes out one clock later. The gain is the product of two factors. The first is a 6-bit volume code that attenuates in 1 dB steps. The second is a soft-mute envelope that follows a raised-cosine curve between unity and silence.

A lock-driven hard mute sits beside the soft mute. When automatic muting is enabled and the upstream source reports that it is not locked, every sample is forced to zero at once, with no ramp. The block also produces a combined lock flag and a mute-status flag.

After reset the envelope rests at silence. Audio reaches the output only after the mute request is cleared and the envelope has climbed back to unity.

Top module: `vol_mute_stage`

## Requirements
- R1: Volume codes 0 and 1 both select a gain of exactly unity (32768 in Q1.15), so a sample passes through unchanged when the envelope is at unity and no hard mute applies.
- R2: A volume code n from 2 to 61 selects the Q1.15 gain round(32768 * 10^(-(n-1)/20)), which is one extra dB of attenuation per code. The applied gain is g = (volume_gain * envelope + 16384) >> 15. The output is (sample * g + 16384) >>> 15, clamped to the signed 24-bit range.
- R3: Volume codes 62 and 63 give an output of zero.
- R4: The envelope has 33 positions p = 0..32 with a Q1.15 value round(32768 * (1 + cos(pi*p/32)) / 2), where p = 0 is unity and p = 32 is zero. While the mute request differs from the rest position, every accepted sample advances a hold counter. After 32 samples on one position the envelope steps one position toward the target, so a full ramp takes 1024 samples. Each sample is scaled by the position held before that sample's own update. The hold counter is cleared whenever the envelope sits at its target (32 when muting, 0 when not).
- R5: When the mute request is cleared part-way through a ramp, the envelope steps back toward unity at the same rate. The hold counter carries on across the reversal without being cleared.
- R6: After reset the envelope is at position 32, mute_active is 1, lock_out is 0, out_valid is 0 and both outputs are 0. A sample sent with the mute request held at 1 comes out as zero.
- R7: mute_active is 1 whenever the envelope is off unity, or the mute request is 1, or the hard mute applies. It is 0 otherwise.
- R8: When auto_mute_en is 1 and lock_out is 0, every sample accepted in that cycle is output as zero, whatever the volume and the envelope. A sample presented one cycle or more after a status flag drops is affected. The envelope keeps moving as usual.
- R9: When auto_mute_en is 0, the lock state has no effect on the output samples.
- R10: lock_out is 1 in the cycle after pll_locked, dec_locked and pcm_flag are all 1, and 0 in the cycle after any of them is 0.
- R11: out_valid pulses one cycle after smp_valid. The output samples hold their value in cycles with no new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe marking a new stereo sample pair |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| vol_code | input | 6 | Volume code, 1 dB per step |
| mute_req | input | 1 | Soft-mute request |
| auto_mute_en | input | 1 | Enables hard mute while unlocked |
| pll_locked | input | 1 | Clock recovery locked |
| dec_locked | input | 1 | Stream decoder locked |
| pcm_flag | input | 1 | Stream carries PCM audio |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | 24 | Left scaled sample, signed |
| out_r | output | 24 | Right scaled sample, signed |
| mute_active | output | 1 | Any mute is in effect |
| lock_out | output | 1 | Combined lock and PCM indication |

## Verification
A scaled sample is due exactly one clock after its strobe. The envelope position that scales it is the one held before the sample's own update. The bench therefore drives each sample on a falling edge and reads out_valid and the data on the next falling edge, then advances its own envelope model. lock_out is due one clock after the status flags change. Each flag change is followed by one full clock before lock_out is compared, and before any sample whose hard-mute result depends on it. mute_active is read on the same falling edge as the sample result, after the envelope has updated.

// File: rtl/vms_pkg.sv
`timescale 1ns/1ps
package vms_pkg;
  localparam int GAIN_W = 16;
  localparam int UNITY  = 1 << (GAIN_W - 1);
  localparam real PI    = 3.141592653589793;

  typedef logic [GAIN_W-1:0] gain_t;

  // Q1.15 gain for a volume code: two codes at 0 dB, 1 dB per code, top two silent
  function automatic gain_t vol_gain(int code, int ncodes);
    if (code <= 1) return gain_t'(UNITY);
    if (code >= ncodes - 2) return '0;
    return gain_t'($rtoi(real'(UNITY) * (10.0 ** (-real'(code - 1) / 20.0)) + 0.5));
  endfunction

  // raised-cosine envelope value for position k of steps
  function automatic gain_t env_coef(int k, int steps);
    return gain_t'($rtoi(real'(UNITY) * (1.0 + $cos(PI * real'(k) / real'(steps))) / 2.0 + 0.5));
  endfunction

  // product of two Q1.15 gains, rounded back to Q1.15
  function automatic gain_t combine_gain(gain_t a, gain_t b);
    logic [2*GAIN_W-1:0] p;
    p = {{GAIN_W{1'b0}}, a} * {{GAIN_W{1'b0}}, b} + (2*GAIN_W)'(UNITY / 2);
    return gain_t'(p >> (GAIN_W - 1));
  endfunction
endpackage

// File: rtl/vms_envelope.sv
`timescale 1ns/1ps
module vms_envelope
  import vms_pkg::*;
#(
  parameter int STEPS  = 32,
  parameter int HOLD_N = 32,
  localparam int STW   = $clog2(STEPS + 1),
  localparam int CW    = $clog2(HOLD_N),
  localparam int IW    = $clog2(STEPS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic           mute_req,
  output gain_t          env_gain,
  output logic [STW-1:0] step,
  output logic           env_active
);
  gain_t          coef_tab [STEPS];
  logic [STW-1:0] step_q, target;
  logic [CW-1:0]  hold_q;
  logic [IW-1:0]  idx;

  for (genvar k = 0; k < STEPS; k++) begin : g_coef
    localparam gain_t C = env_coef(k + 1, STEPS);
    assign coef_tab[k] = C;
  end

  assign target = mute_req ? STW'(STEPS) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= STW'(STEPS);
      hold_q <= '0;
    end else if (adv) begin
      if (step_q == target) begin
        hold_q <= '0;
      end else if (hold_q == CW'(HOLD_N - 1)) begin
        hold_q <= '0;
        step_q <= mute_req ? step_q + STW'(1) : step_q - STW'(1);
      end else begin
        hold_q <= hold_q + CW'(1);
      end
    end
  end

  assign idx        = IW'(step_q - STW'(1));
  assign env_gain   = (step_q == '0) ? gain_t'(UNITY) : coef_tab[idx];
  assign step       = step_q;
  assign env_active = (step_q != '0) | mute_req;
endmodule

// File: rtl/vms_scaler.sv
`timescale 1ns/1ps
module vms_scaler
  import vms_pkg::*;
#(
  parameter int SW = 24,
  localparam int PW = SW + GAIN_W + 1
) (
  input  logic signed [SW-1:0] smp,
  input  gain_t                gain,
  output logic signed [SW-1:0] scaled
);
  localparam logic signed [PW-1:0] HI = {{(PW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = ~HI;

  logic signed [PW-1:0] prod, rnd;

  always_comb begin
    prod = PW'(smp) * PW'($signed({1'b0, gain}));
    rnd  = (prod + PW'(UNITY / 2)) >>> (GAIN_W - 1);
    if (rnd > HI)      scaled = SW'(HI);
    else if (rnd < LO) scaled = SW'(LO);
    else               scaled = SW'(rnd);
  end
endmodule

// File: rtl/vms_lock_gate.sv
`timescale 1ns/1ps
module vms_lock_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_ok,
  input  logic dec_ok,
  input  logic pcm_ok,
  output logic lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= pll_ok & dec_ok & pcm_ok;
  end
endmodule

// File: rtl/vol_mute_stage.sv
`timescale 1ns/1ps
module vol_mute_stage
  import vms_pkg::*;
#(
  parameter int SW    = 24,
  parameter int VCW   = 6,
  parameter int STEPS = 32,
  parameter int HOLD  = 32,
  localparam int NCODES = 2 ** VCW,
  localparam int STW    = $clog2(STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] in_l,
  input  logic signed [SW-1:0] in_r,
  input  logic [VCW-1:0]       vol_code,
  input  logic                 mute_req,
  input  logic                 auto_mute_en,
  input  logic                 pll_locked,
  input  logic                 dec_locked,
  input  logic                 pcm_flag,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_l,
  output logic signed [SW-1:0] out_r,
  output logic                 mute_active,
  output logic                 lock_out
);
  gain_t                vol_tab [NCODES];
  gain_t                vol_g, env_g, comb_g;
  logic [STW-1:0]       env_step;
  logic                 env_active, hard_mute;
  logic signed [SW-1:0] chan_in  [2];
  logic signed [SW-1:0] chan_sc  [2];
  logic signed [SW-1:0] out_q    [2];

  for (genvar c = 0; c < NCODES; c++) begin : g_vol
    localparam gain_t G = vol_gain(c, NCODES);
    assign vol_tab[c] = G;
  end

  vms_envelope #(.STEPS(STEPS), .HOLD_N(HOLD)) u_env (
    .clk(clk), .rst_n(rst_n), .adv(smp_valid), .mute_req(mute_req),
    .env_gain(env_g), .step(env_step), .env_active(env_active)
  );

  vms_lock_gate u_lock (
    .clk(clk), .rst_n(rst_n), .pll_ok(pll_locked), .dec_ok(dec_locked),
    .pcm_ok(pcm_flag), .lock_q(lock_out)
  );

  assign vol_g     = vol_tab[vol_code];
  assign comb_g    = combine_gain(vol_g, env_g);
  assign hard_mute = auto_mute_en & ~lock_out;
  assign chan_in[0] = in_l;
  assign chan_in[1] = in_r;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    vms_scaler #(.SW(SW)) u_sc (
      .smp(chan_in[ch]), .gain(comb_g), .scaled(chan_sc[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      for (int ch = 0; ch < 2; ch++) out_q[ch] <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid)
        for (int ch = 0; ch < 2; ch++) out_q[ch] <= hard_mute ? '0 : chan_sc[ch];
    end
  end

  assign out_l       = out_q[0];
  assign out_r       = out_q[1];
  assign mute_active = env_active | hard_mute;
endmodule

// File: rtl/vms_checker.sv
`timescale 1ns/1ps
module vms_checker #(
  parameter int SW  = 24,
  parameter int VCW = 6,
  parameter int STW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic [VCW-1:0]       vol_code,
  input logic                 auto_mute_en,
  input logic                 pll_locked,
  input logic                 dec_locked,
  input logic                 pcm_flag,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_l,
  input logic signed [SW-1:0] out_r,
  input logic                 mute_active,
  input logic                 lock_out,
  input logic [STW-1:0]       env_step
);
  // R10
  lock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_locked && dec_locked && pcm_flag) |=> lock_out);
  // R10
  lock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pll_locked && dec_locked && pcm_flag) |=> !lock_out);
  // R8
  hard_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && auto_mute_en && !lock_out) |=> (out_l == '0 && out_r == '0));
  // R3
  silent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && vol_code >= VCW'(2**VCW - 2)) |=> (out_l == '0 && out_r == '0));
  // R11
  strobe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!out_valid && $stable(out_l) && $stable(out_r)));
  // R7
  idle_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_active |-> env_step == '0);
  // R4
  step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (env_step == $past(env_step) || env_step == $past(env_step) + STW'(1) ||
     env_step == $past(env_step) - STW'(1)));
endmodule

bind vol_mute_stage vms_checker #(.SW(SW), .VCW(VCW), .STW(STW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .vol_code(vol_code),
  .auto_mute_en(auto_mute_en), .pll_locked(pll_locked), .dec_locked(dec_locked),
  .pcm_flag(pcm_flag), .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
  .mute_active(mute_active), .lock_out(lock_out), .env_step(env_step)
);

// File: tb/sim_vol_mute_stage.sv
`timescale 1ns/1ps
module sim_vol_mute_stage;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic [5:0]         vol_code = '0;
  logic               mute_req = 1'b1, auto_mute_en = 1'b1;
  logic               pll_locked = 1'b0, dec_locked = 1'b0, pcm_flag = 1'b0;
  logic               out_valid, mute_active, lock_out;
  logic signed [23:0] out_l, out_r;

  int n_chk = 0, n_bad = 0;
  int ref_s = 32, ref_cnt = 0;
  bit ref_lock = 0;

  always #2 clk = ~clk;

  vol_mute_stage u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .in_l(in_l), .in_r(in_r),
    .vol_code(vol_code), .mute_req(mute_req), .auto_mute_en(auto_mute_en),
    .pll_locked(pll_locked), .dec_locked(dec_locked), .pcm_flag(pcm_flag),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .mute_active(mute_active), .lock_out(lock_out)
  );

  function automatic longint ref_vol(int n);
    if (n <= 1) return 32768;
    if (n >= 62) return 0;
    return longint'($rtoi(32768.0 * $pow(10.0, -(n - 1) / 20.0) + 0.5));
  endfunction

  function automatic longint ref_env(int p);
    if (p == 0) return 32768;
    return longint'($rtoi(16384.0 * (1.0 + $cos($acos(-1.0) * p / 32.0)) + 0.5));
  endfunction

  function automatic longint ref_out(longint x, longint g);
    longint r;
    r = (x * g + 16384) >>> 15;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one sample through the stage, compared against the model
  task automatic send(longint l, longint r, string req);
    longint g, el, er;
    int tgt;
    bit exp_ma;
    in_l = 24'(l); in_r = 24'(r); smp_valid = 1'b1;
    g  = (ref_vol(int'(vol_code)) * ref_env(ref_s) + 16384) >> 15;
    el = (auto_mute_en && !ref_lock) ? 0 : ref_out(l, g);
    er = (auto_mute_en && !ref_lock) ? 0 : ref_out(r, g);
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
    tgt = mute_req ? 32 : 0;
    if (ref_s == tgt) ref_cnt = 0;
    else if (ref_cnt == 31) begin ref_cnt = 0; ref_s = mute_req ? ref_s + 1 : ref_s - 1; end
    else ref_cnt++;
    chk(out_valid == 1'b1, "R11 strobe", longint'(out_valid), 1);
    chk(out_l == el, req, out_l, el);
    chk(out_r == er, req, out_r, er);
    exp_ma = (ref_s != 0) || mute_req || (auto_mute_en && !ref_lock);
    chk(mute_active == exp_ma, "R7 mute_active", longint'(mute_active), longint'(exp_ma));
  endtask

  task automatic set_flags(bit p, bit d, bit c, bit a);
    pll_locked = p; dec_locked = d; pcm_flag = c; auto_mute_en = a;
    @(posedge clk); @(negedge clk);
    ref_lock = p & d & c;
    chk(lock_out == ref_lock, "R10 lock_out", longint'(lock_out), longint'(ref_lock));
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R6 out_valid", longint'(out_valid), 0);
    chk(out_l == 0 && out_r == 0, "R6 outputs", out_l, 0);
    chk(mute_active == 1'b1, "R6 mute_active", longint'(mute_active), 1);
    chk(lock_out == 1'b0, "R6 lock_out", longint'(lock_out), 0);
    set_flags(1, 1, 1, 1);
    send(1000000, -1000000, "R6 muted after reset");
  endtask

  task automatic t_lock();
    set_flags(0, 1, 1, 1);
    set_flags(1, 0, 1, 1);
    set_flags(1, 1, 0, 1);
    set_flags(1, 1, 1, 1);
  endtask

  task automatic t_unmute();
    mute_req = 1'b0;
    for (int i = 0; i < 1030; i++) send(4194303, -2097153 + i, "R4 ramp up");
    chk(mute_active == 1'b0, "R7 idle at unity", longint'(mute_active), 0);
  endtask

  task automatic t_volume();
    int codes [10] = '{0, 1, 2, 3, 7, 20, 40, 61, 62, 63};
    foreach (codes[i]) begin
      vol_code = 6'(codes[i]);
      send(8388607, -8388608, codes[i] <= 1 ? "R1 unity code" :
                              codes[i] >= 62 ? "R3 silent code" : "R2 dB step");
      send(12345, -777, codes[i] <= 1 ? "R1 unity code" :
                        codes[i] >= 62 ? "R3 silent code" : "R2 dB step");
    end
    vol_code = 6'd0;
    chk(ref_vol(61) == longint'($rtoi(32768.0 / 1000.0 + 0.5)), "R2 -60 dB", ref_vol(61), 33);
  endtask

  task automatic t_softmute();
    mute_req = 1'b1;
    vol_code = 6'd5;
    for (int i = 0; i < 1030; i++) send(-3000000, 3000000 - 7 * i, "R4 ramp down");
    chk(out_l == 0, "R4 silent after 1024", out_l, 0);
    vol_code = 6'd0;
  endtask

  task automatic t_reverse();
    mute_req = 1'b0;
    for (int i = 0; i < 1030; i++) send(5000000, -5000000, "R4 restore");
    mute_req = 1'b1;
    for (int i = 0; i < 203; i++) send(5000000, 123, "R5 partial down");
    mute_req = 1'b0;
    for (int i = 0; i < 260; i++) send(5000000, 123, "R5 reverse up");
    chk(mute_active == 1'b0, "R5 back at unity", longint'(mute_active), 0);
  endtask

  task automatic t_hard();
    set_flags(1, 1, 0, 1);
    send(4000000, -4000000, "R8 hard mute");
    chk(mute_active == 1'b1, "R8 mute_active", longint'(mute_active), 1);
    set_flags(1, 1, 1, 1);
    send(4000000, -4000000, "R8 envelope untouched");
    set_flags(0, 0, 0, 0);
    send(4000000, -4000000, "R9 auto-mute off");
    set_flags(1, 1, 1, 1);
  endtask

  task automatic t_hold();
    logic signed [23:0] held;
    send(777777, -1, "R11 sample");
    held = out_l;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 no strobe", longint'(out_valid), 0);
    chk(out_l == held, "R11 hold", out_l, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_unmute();
    t_volume();
    t_softmute();
    t_reverse();
    t_hard();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule